// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 64 interrupt lines into a single request to a processor. Each line has its own setup word that picks level or edge sensitivity and a 4-bit priority level. A line is a candidate when it is pending, enabled and has a non-zero priority. The highest priority among candidates wins, and equal priorities resolve to the lowest line number. Software reads the winning line number from a vector register. A value of 64 in that register means nothing qualifies.

Software runs the block over a simple 32-bit register bus that accepts one access per cycle. Read data returns one cycle after the access. Enables are changed through write-one-to-set and write-one-to-clear words, each covering 32 lines. A global enable gates the request. A software reset word clears every register.

Reading a valid vector records that line's priority as the level in service. The request is then raised only for a strictly higher priority. Any write to the end-of-interrupt word closes the service. Edge latches stay set until software rewrites that line's setup word.

Top module: `vic_top`

## Requirements
- R1: After reset `irq_o` is low, the vector register reads 64, and every enable word and setup word reads 0.
- R2: A write to enable-set word k (byte 0x020 + 8k) sets enable bit 32k+i for each 1 in data bit i. A write to disable word k (byte 0x030 + 8k) clears those bits. Zero data bits leave enables unchanged. An enable-set word reads back the current 32 enable bits of its half.
- R3: The vector register (byte 0x010) reads the number of the candidate with the highest priority. Ties go to the lowest number. It reads 64 when there is no candidate.
- R4: A line whose priority field is 0 is never selected, even when it is pending and enabled.
- R5: A level line (edge bit 0) is pending only while its input is high. Once the input falls, it drops out of selection within three cycles.
- R6: An edge line (edge bit 1) latches a rising edge of its input and stays pending after the input falls. A write to its setup word clears the latch. If a rising edge arrives in the same cycle as that write, the latch ends up set. A steady high input does not set the latch again.
- R7: `irq_o` stays low while the global enable (byte 0x008, bit 0) is 0, even when a candidate exists. It rises within three cycles after the enable is set.
- R8: A vector read that returns a valid line records that line's priority as in service. From then on, `irq_o` is raised only for a strictly higher priority. Any write to the end-of-interrupt word (byte 0x018) ends service whatever the data.
- R9: Writing 1 to bit 0 of the reset word (byte 0x000) returns every register to zero: enables, setup words, global enable, edge latches and in-service state. A write with bit 0 clear has no effect.
- R10: Setup word n is at byte 0x200 + 8n, with priority in bits 3:0 and the edge bit at bit 8. Reads of the reset word, the end-of-interrupt word, the disable words, unmapped or misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_in | input | 64 | Interrupt lines, already synchronous to clk |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The interaction that matters most is an edge line's latch when a rising input edge lands in the same cycle as a write to that line's setup word. The write clears the latch and the edge sets it, so one of the two has to win. The bench raises the input one cycle ahead of the bus write, so the detected edge and the clear meet at the same clock edge. It then reads the vector register and expects that line's number rather than 64, which shows the edge was not lost. A separate run with a steady high input across a setup rewrite checks the other case: the latch must clear and must not set again.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NUM_SRC     = 64;
    localparam int PRIO_W      = 4;
    localparam int DW          = 32;
    localparam int AW          = 12;
    localparam int ID_W        = $clog2(NUM_SRC) + 1;
    localparam int EN_WORDS    = NUM_SRC / DW;
    localparam int TREE_LVLS   = $clog2(NUM_SRC);
    localparam int TREE_LEAVES = 1 << TREE_LVLS;
    localparam int WORD_W      = AW - 3;

    // word indices (byte address / 8)
    localparam int W_RST    = 0;
    localparam int W_GEN    = 1;
    localparam int W_VEC    = 2;
    localparam int W_EOI    = 3;
    localparam int W_ENS0   = 4;
    localparam int W_DIS0   = W_ENS0 + EN_WORDS;
    localparam int W_SETUP0 = 64;
    localparam int SETUP_EDGE_BIT = 8;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [ID_W-1:0]   src_id_t;

    typedef struct packed {
        logic    valid;
        prio_t   prio;
        src_id_t id;
    } cand_t;

    typedef enum logic [2:0] {
        RK_NONE, RK_RST, RK_GEN, RK_VEC, RK_EOI, RK_ENS, RK_DIS, RK_SETUP
    } reg_kind_t;

    typedef struct packed {
        reg_kind_t kind;
        src_id_t   idx;
    } reg_dec_t;

    function automatic cand_t cand_pick(cand_t lo, cand_t hi);
        if (lo.valid && (!hi.valid || lo.prio >= hi.prio)) return lo;
        return hi;
    endfunction

    function automatic reg_dec_t reg_decode(logic [AW-1:0] addr);
        reg_dec_t d;
        int w;
        d.kind = RK_NONE;
        d.idx  = '0;
        w = int'(addr[AW-1:3]);
        if (addr[2:0] == 3'b000) begin
            if (w == W_RST)      d.kind = RK_RST;
            else if (w == W_GEN) d.kind = RK_GEN;
            else if (w == W_VEC) d.kind = RK_VEC;
            else if (w == W_EOI) d.kind = RK_EOI;
            else if (w >= W_ENS0 && w < W_ENS0 + EN_WORDS) begin
                d.kind = RK_ENS;
                d.idx  = src_id_t'(w - W_ENS0);
            end else if (w >= W_DIS0 && w < W_DIS0 + EN_WORDS) begin
                d.kind = RK_DIS;
                d.idx  = src_id_t'(w - W_DIS0);
            end else if (w >= W_SETUP0 && w < W_SETUP0 + NUM_SRC) begin
                d.kind = RK_SETUP;
                d.idx  = src_id_t'(w - W_SETUP0);
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic [AW-1:0]                bus_addr,
    input  logic [DW-1:0]                bus_wdata,
    output logic [DW-1:0]                bus_rdata,
    input  cand_t                        win,
    output logic [NUM_SRC-1:0]           enable,
    output logic [NUM_SRC-1:0]           edge_mode,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic                         gen_en,
    output logic [NUM_SRC-1:0]           setup_wr,
    output logic                         soft_clr,
    output logic                         eoi_pulse,
    output logic                         vec_read
);
    reg_dec_t    dec;
    logic        wr;
    logic [DW-1:0] rd_mux;

    assign dec       = reg_decode(bus_addr);
    assign wr        = bus_valid && bus_write;
    assign soft_clr  = wr && (dec.kind == RK_RST) && bus_wdata[0];
    assign eoi_pulse = wr && (dec.kind == RK_EOI);
    assign vec_read  = bus_valid && !bus_write && (dec.kind == RK_VEC);

    always_comb begin
        setup_wr = '0;
        for (int s = 0; s < NUM_SRC; s++)
            if (wr && dec.kind == RK_SETUP && int'(dec.idx) == s) setup_wr[s] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            enable    <= '0;
            edge_mode <= '0;
            prio      <= '0;
            gen_en    <= 1'b0;
        end else if (wr) begin
            case (dec.kind)
                RK_GEN: gen_en <= bus_wdata[0];
                RK_ENS: begin
                    for (int k = 0; k < EN_WORDS; k++)
                        if (int'(dec.idx) == k)
                            enable[k*DW +: DW] <= enable[k*DW +: DW] | bus_wdata;
                end
                RK_DIS: begin
                    for (int k = 0; k < EN_WORDS; k++)
                        if (int'(dec.idx) == k)
                            enable[k*DW +: DW] <= enable[k*DW +: DW] & ~bus_wdata;
                end
                RK_SETUP: begin
                    for (int s = 0; s < NUM_SRC; s++)
                        if (setup_wr[s]) begin
                            prio[s]      <= bus_wdata[PRIO_W-1:0];
                            edge_mode[s] <= bus_wdata[SETUP_EDGE_BIT];
                        end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (dec.kind)
            RK_GEN: rd_mux[0] = gen_en;
            RK_VEC: rd_mux = win.valid ? DW'(win.id) : DW'(NUM_SRC);
            RK_ENS: begin
                for (int k = 0; k < EN_WORDS; k++)
                    if (int'(dec.idx) == k) rd_mux = enable[k*DW +: DW];
            end
            RK_SETUP: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (int'(dec.idx) == s) begin
                        rd_mux[PRIO_W-1:0]     = prio[s];
                        rd_mux[SETUP_EDGE_BIT] = edge_mode[s];
                    end
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
        else bus_rdata <= '0;
    end

    // R2: a disable write leaves none of the written bits enabled
    p_w1c_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.kind == RK_DIS && dec.idx == '0)
            |=> ((enable[DW-1:0] & $past(bus_wdata)) == '0));

    // R9: a soft reset leaves the global enable off
    p_soft_clear_r9: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (!gen_en && enable == '0));
endmodule

// File: rtl/vic_pending.sv
module vic_pending
    import vic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_clr,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] edge_mode,
    input  logic [NUM_SRC-1:0] setup_wr,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] src_prev;
    logic [NUM_SRC-1:0] edge_q;
    logic [NUM_SRC-1:0] rise;

    assign rise = src_q & ~src_prev;

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            src_q    <= '0;
            src_prev <= '0;
            edge_q   <= '0;
        end else begin
            src_q    <= irq_in;
            src_prev <= src_q;
            // a new edge wins over a clear by setup rewrite in the same cycle
            edge_q   <= (edge_q & ~setup_wr) | (rise & edge_mode);
        end
    end

    assign pend = (edge_mode & edge_q) | (~edge_mode & src_q);

    // R6: a latched edge survives until its setup word is written
    p_edge_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !soft_clr |=> (($past(edge_q & ~setup_wr) & ~edge_q) == '0));

    // R6: a latch only appears for a line in edge mode that saw a rise
    p_edge_cause_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((edge_q & ~$past(edge_q) & ~$past(rise & edge_mode)) == '0));
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0]             enable,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output cand_t                          win
);
    cand_t tree [1:2*TREE_LEAVES-1];

    genvar j;
    generate
        for (j = 0; j < TREE_LEAVES; j++) begin : g_leaf
            if (j < NUM_SRC) begin : g_real
                assign tree[TREE_LEAVES+j] = '{
                    valid: pend[j] && enable[j] && (prio[j] != '0),
                    prio:  prio[j],
                    id:    src_id_t'(j)
                };

                // R3: no candidate beats the winner
                p_win_max_r3: assert property (@(posedge clk) disable iff (rst)
                    tree[TREE_LEAVES+j].valid |-> (win.valid && win.prio >= prio[j]));

                // R3: equal priority resolves to the lower number
                p_tie_low_r3: assert property (@(posedge clk) disable iff (rst)
                    (tree[TREE_LEAVES+j].valid && win.prio == prio[j])
                        |-> (win.id <= src_id_t'(j)));
            end else begin : g_pad
                assign tree[TREE_LEAVES+j] = '0;
            end
        end
        for (j = 1; j < TREE_LEAVES; j++) begin : g_node
            assign tree[j] = cand_pick(tree[2*j], tree[2*j+1]);
        end
    endgenerate

    assign win = tree[1];

    // R4: a winner never carries priority zero
    p_win_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (win.prio != '0));
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [63:0]        irq_in,
    output logic               irq_o
);
    logic [NUM_SRC-1:0]             enable;
    logic [NUM_SRC-1:0]             edge_mode;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [NUM_SRC-1:0]             setup_wr;
    logic [NUM_SRC-1:0]             pend;
    logic                           gen_en;
    logic                           soft_clr;
    logic                           eoi_pulse;
    logic                           vec_read;
    cand_t                          win;
    logic                           svc_active;
    prio_t                          svc_prio;

    vic_regs u_regs (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .win(win), .enable(enable), .edge_mode(edge_mode), .prio(prio),
        .gen_en(gen_en), .setup_wr(setup_wr), .soft_clr(soft_clr),
        .eoi_pulse(eoi_pulse), .vec_read(vec_read)
    );

    vic_pending u_pend (
        .clk(clk), .rst(rst), .soft_clr(soft_clr),
        .irq_in(irq_in), .edge_mode(edge_mode), .setup_wr(setup_wr),
        .pend(pend)
    );

    vic_arbiter u_arb (
        .clk(clk), .rst(rst),
        .pend(pend), .enable(enable), .prio(prio), .win(win)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            svc_active <= 1'b0;
            svc_prio   <= '0;
        end else if (vec_read && win.valid) begin
            svc_active <= 1'b1;
            svc_prio   <= win.prio;
        end else if (eoi_pulse) begin
            svc_active <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) irq_o <= 1'b0;
        else irq_o <= gen_en && win.valid && (!svc_active || win.prio > svc_prio);
    end

    // R7: with generation off the request stays low
    p_gen_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> !irq_o);

    // R8: an in-service level blocks equal or lower winners
    p_svc_block_r8: assert property (@(posedge clk) disable iff (rst)
        (svc_active && win.prio <= svc_prio) |=> !irq_o);

    // R8: a valid vector read records the winner's level
    p_vec_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (vec_read && win.valid) |=> (svc_active && svc_prio == $past(win.prio)));
endmodule

// File: tb/vic_top_bench.sv
`timescale 1ns/1ps
module vic_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [63:0] irq_in;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [11:0] A_RST = 12'h000, A_GEN = 12'h008, A_VEC = 12'h010,
                            A_EOI = 12'h018, A_ENS0 = 12'h020, A_ENS1 = 12'h028,
                            A_DIS0 = 12'h030, A_DIS1 = 12'h038;

    always #4 clk = ~clk;

    vic_top u_vic_top (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_o(irq_o)
    );

    function automatic logic [11:0] a_setup(int n);
        return 12'(12'h200 + n * 8);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        bus_rd(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clean();
        irq_in = '0;
        bus_wr(A_RST, 32'h1);
        idle(2);
    endtask

    task automatic t_reset();
        check(irq_o == 1'b0, "R1 irq after reset", 32'(irq_o), 0);
        expect_rd(A_VEC, 64, "R1 vector after reset");
        expect_rd(A_ENS0, 0, "R1 enable low after reset");
        expect_rd(A_ENS1, 0, "R1 enable high after reset");
        expect_rd(a_setup(5), 0, "R1 setup after reset");
    endtask

    task automatic t_enable();
        bus_wr(A_ENS0, 32'h0000_00F0);
        bus_wr(A_ENS1, 32'h0000_0001);
        expect_rd(A_ENS0, 32'h0000_00F0, "R2 set low half");
        expect_rd(A_ENS1, 32'h0000_0001, "R2 set high half");
        bus_wr(A_DIS0, 32'h0000_0030);
        expect_rd(A_ENS0, 32'h0000_00C0, "R2 clear two bits");
        bus_wr(A_ENS0, 32'h0);
        expect_rd(A_ENS0, 32'h0000_00C0, "R2 zero bits no effect");
        bus_wr(A_DIS1, 32'h0);
        expect_rd(A_ENS1, 32'h0000_0001, "R2 zero disable no effect");
        expect_rd(A_DIS0, 0, "R10 disable word reads zero");
        expect_rd(A_EOI, 0, "R10 eoi word reads zero");
        expect_rd(A_RST, 0, "R10 reset word reads zero");
        expect_rd(12'h024, 0, "R10 misaligned reads zero");
        clean();
    endtask

    task automatic t_arb();
        bus_wr(a_setup(3), 32'h2);
        bus_wr(a_setup(10), 32'h5);
        bus_wr(a_setup(40), 32'h5);
        expect_rd(a_setup(40), 32'h5, "R10 setup readback");
        bus_wr(A_ENS0, 32'h0000_0488);   // lines 3, 7, 10
        bus_wr(A_ENS1, 32'h0000_0100);   // line 40
        irq_in[3] = 1; irq_in[10] = 1; irq_in[40] = 1;
        idle(3);
        expect_rd(A_VEC, 10, "R3 tie goes to lowest number");
        irq_in[10] = 0; idle(3);
        expect_rd(A_VEC, 40, "R3 highest priority high half");
        bus_wr(a_setup(40), 32'h1); idle(1);
        expect_rd(A_VEC, 3, "R3 priority change reorders");
        irq_in[3] = 0; irq_in[40] = 0; idle(3);
        expect_rd(A_VEC, 64, "R3 nothing pending reads 64");
        irq_in[7] = 1; idle(3);
        expect_rd(A_VEC, 64, "R4 zero priority never wins");
        clean();
    endtask

    task automatic t_level();
        bus_wr(a_setup(12), 32'h3);
        bus_wr(A_ENS0, 32'h0000_1000);
        bus_wr(A_GEN, 32'h1);
        irq_in[12] = 1; idle(3);
        check(irq_o == 1'b1, "R5 level raises request", 32'(irq_o), 1);
        irq_in[12] = 0; idle(3);
        check(irq_o == 1'b0, "R5 level drops request", 32'(irq_o), 0);
        expect_rd(A_VEC, 64, "R5 level not held after fall");
        clean();
    endtask

    task automatic t_gen();
        bus_wr(a_setup(33), 32'h6);
        bus_wr(A_ENS1, 32'h0000_0002);
        irq_in[33] = 1; idle(5);
        check(irq_o == 1'b0, "R7 gated while global enable off", 32'(irq_o), 0);
        bus_wr(A_GEN, 32'h1);
        expect_rd(A_GEN, 1, "R7 global enable readback");
        check(irq_o == 1'b1, "R7 request after global enable", 32'(irq_o), 1);
        bus_wr(A_GEN, 32'h0); idle(2);
        check(irq_o == 1'b0, "R7 request drops when gated", 32'(irq_o), 0);
        clean();
    endtask

    task automatic t_edge();
        bus_wr(a_setup(20), 32'h104);
        bus_wr(A_ENS0, 32'h0010_0000);
        bus_wr(A_GEN, 32'h1);
        idle(2);
        irq_in[20] = 1; idle(1); irq_in[20] = 0;
        idle(3);
        check(irq_o == 1'b1, "R6 pulse latched after input fell", 32'(irq_o), 1);
        bus_wr(A_EOI, 32'h0);
        expect_rd(A_VEC, 20, "R6 edge line reported");
        bus_wr(a_setup(20), 32'h104); idle(1);
        expect_rd(A_VEC, 64, "R6 setup rewrite clears latch");
        irq_in[20] = 1; idle(4);
        expect_rd(A_VEC, 20, "R6 new rise latches");
        bus_wr(a_setup(20), 32'h104); idle(2);
        expect_rd(A_VEC, 64, "R6 steady high does not relatch");
        irq_in[20] = 0; idle(3);
        // rise and setup rewrite meet at the same clock edge
        @(negedge clk);
        irq_in[20] = 1;
        bus_wr(a_setup(20), 32'h104);
        idle(2);
        expect_rd(A_VEC, 20, "R6 coincident edge survives rewrite");
        clean();
    endtask

    task automatic t_service();
        bus_wr(a_setup(12), 32'h3);
        bus_wr(a_setup(50), 32'h9);
        bus_wr(A_ENS0, 32'h0000_1000);
        bus_wr(A_ENS1, 32'h0004_0000);
        bus_wr(A_GEN, 32'h1);
        irq_in[12] = 1; idle(3);
        check(irq_o == 1'b1, "R8 request before service", 32'(irq_o), 1);
        expect_rd(A_VEC, 12, "R8 vector read takes line 12");
        idle(2);
        check(irq_o == 1'b0, "R8 equal level blocked in service", 32'(irq_o), 0);
        bus_wr(A_EOI, 32'h0000_1234);
        idle(2);
        check(irq_o == 1'b1, "R8 eoi with data reopens", 32'(irq_o), 1);
        expect_rd(A_VEC, 12, "R8 reread line 12");
        idle(2);
        check(irq_o == 1'b0, "R8 blocked again", 32'(irq_o), 0);
        irq_in[50] = 1; idle(3);
        check(irq_o == 1'b1, "R8 higher level preempts", 32'(irq_o), 1);
        expect_rd(A_VEC, 50, "R8 higher line reported");
        clean();
    endtask

    task automatic t_soft_reset();
        bus_wr(a_setup(9), 32'h107);
        bus_wr(A_ENS0, 32'h0000_0200);
        bus_wr(A_GEN, 32'h1);
        irq_in[9] = 1; idle(2); irq_in[9] = 0; idle(3);
        bus_wr(A_RST, 32'h0000_0002);
        expect_rd(A_ENS0, 32'h0000_0200, "R9 bit0 clear no effect");
        check(irq_o == 1'b1, "R9 request kept on ignored reset", 32'(irq_o), 1);
        bus_wr(A_RST, 32'h1);
        expect_rd(A_ENS0, 0, "R9 enables cleared");
        expect_rd(a_setup(9), 0, "R9 setup cleared");
        expect_rd(A_GEN, 0, "R9 global enable cleared");
        check(irq_o == 1'b0, "R9 request cleared", 32'(irq_o), 0);
        bus_wr(a_setup(9), 32'h107);
        bus_wr(A_ENS0, 32'h0000_0200);
        idle(2);
        expect_rd(A_VEC, 64, "R9 edge latch cleared");
        clean();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        irq_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_enable();
        t_arb();
        t_level();
        t_gen();
        t_edge();
        t_service();
        t_soft_reset();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end
endmodule